// File: doc/BRIEF.md
# Privilege Mode Tracking Unit

This block holds the privilege level a hart is currently running at, as a hidden register. No control-register address can read it; software can only infer it from what traps. The unit tracks three levels (user, supervisor, machine) and can be built with fewer. Trap-entry and return strobes from the pipeline move the level. The unit also keeps the status fields that those moves read and write: the machine previous-privilege field, the supervisor previous-privilege bit, the modify-privilege bit and the trap-return-from-supervisor bit.

Each cycle the unit gives three results. The first is the privilege for instruction fetch, which is always the current level. The second is the privilege for loads and stores. When the modify-privilege bit is set, this takes the level held in the machine previous-privilege field. The third is a combinational flag that marks a return strobe as illegal in the current state. The pipeline turns that flag into an illegal-instruction exception. An illegal return changes no state. Software updates to the status fields come in on a write strobe. They are filtered so that only supported values are kept.

Top module: `priv_mode_tracker`

## Requirements
- R1: Mode encoding is user=2'b00, supervisor=2'b01, machine=2'b11. After a synchronous active-low reset the level is machine, the modify-privilege bit is 0, the supervisor previous bit is 0, the trap-return bit is 0, and the machine previous field holds user, or machine when user mode is absent.
- R2: A trap that targets machine mode makes the level machine in the next cycle and stores the level held before the trap in the machine previous field.
- R3: A trap with the supervisor-target input set, taken from user or supervisor level, makes the level supervisor and sets the supervisor previous bit to 1 exactly when the prior level was supervisor. The same request taken from machine level, or in a build without supervisor mode, goes to machine as in R2.
- R4: A legal machine return sets the level to the machine previous field and then sets that field to user. It clears the modify-privilege bit when the new level is below machine and keeps it when the new level is machine.
- R5: A legal supervisor return sets the level to supervisor when the supervisor previous bit is 1 and to user when it is 0. It then clears that bit and clears the modify-privilege bit.
- R6: The illegal flag is raised in the same cycle as the strobe for a machine return outside machine level, for a supervisor return in user level, and for a supervisor return in supervisor level with the trap-return bit set. No state changes on such a strobe.
- R7: A supervisor return at machine level is never illegal, whatever the trap-return bit holds.
- R8: Fetch privilege always equals the current level. Data privilege equals the machine previous field when the modify-privilege bit is 1, and the current level otherwise.
- R9: A status write stores the machine previous field only for a supported encoding (2'b10 is never kept). A trap or return in the same cycle takes precedence and the write is dropped. If both return strobes are set, the machine return is taken.
- R10: In a machine+user build, the trap-return bit and the supervisor previous bit read 0, a supervisor return is always illegal, a write of supervisor into the machine previous field is dropped, and the modify-privilege bit stays writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid | input | 1 | A trap (exception, interrupt, environment call) is taken this cycle |
| trap_to_s | input | 1 | The trap is delegated to supervisor level |
| mret_valid | input | 1 | Machine return instruction retires this cycle |
| sret_valid | input | 1 | Supervisor return instruction retires this cycle |
| ctl_wr_valid | input | 1 | Software write of the status fields |
| ctl_wr_mprv | input | 1 | Written modify-privilege bit |
| ctl_wr_mpp | input | 2 | Written machine previous-privilege field |
| ctl_wr_spp | input | 1 | Written supervisor previous-privilege bit |
| ctl_wr_tsr | input | 1 | Written trap-return-from-supervisor bit |
| cur_priv | output | 2 | Current privilege level (hidden from software) |
| fetch_priv | output | 2 | Privilege for instruction fetch |
| data_priv | output | 2 | Privilege for loads and stores |
| ctl_mprv | output | 1 | Modify-privilege bit |
| ctl_mpp | output | 2 | Machine previous-privilege field |
| ctl_spp | output | 1 | Supervisor previous-privilege bit |
| ctl_tsr | output | 1 | Trap-return-from-supervisor bit |
| ret_illegal | output | 1 | The return strobe this cycle is illegal |

## Verification
The bench builds the unit twice. One copy has MODES=3, with all three levels. It walks a vector table through every entry and return path, including a supervisor trap requested from machine level, a supervisor return at machine level with the trap-return bit set, and a machine return into machine with the modify-privilege bit kept. The second copy has MODES=2. It shows the fields that are forced to zero, the supervisor encoding being rejected, and every supervisor return being flagged illegal, which cannot happen when supervisor mode exists.

// File: rtl/priv_pkg.sv
// Package priv_pkg
// Shared privilege encoding for the privilege tracking unit.
// Assumes a two-bit level code; 2'b10 is reserved and never stored.
package priv_pkg;
    typedef enum logic [1:0] {
        LVL_U = 2'b00,
        LVL_S = 2'b01,
        LVL_M = 2'b11
    } priv_t;
endpackage

// File: rtl/priv_return_check.sv
// Module priv_return_check
// Decides whether a return strobe is legal in the current level and
// produces the go strobes for the state registers plus the illegal flag.
// Assumes a trap in the same cycle pre-empts any return (no go, no flag),
// and a machine return wins over a supervisor return when both are set.
module priv_return_check
    import priv_pkg::*;
#(
    parameter int MODES = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  trap_valid,
    input  logic  mret_valid,
    input  logic  sret_valid,
    input  priv_t cur_mode,
    input  logic  tsr,
    output logic  mret_go,
    output logic  sret_go,
    output logic  illegal
);
    localparam bit HAS_S = (MODES >= 3);

    logic mret_req;
    logic sret_req;
    logic mret_legal;
    logic sret_legal;

    // Qualify the requests: traps pre-empt, machine return wins ties.
    always_comb begin
        mret_req = mret_valid && !trap_valid;
        sret_req = sret_valid && !trap_valid && !mret_valid;
    end

    // Legality of each return in the present level.
    always_comb begin
        mret_legal = (cur_mode == LVL_M);
        sret_legal = HAS_S && ((cur_mode == LVL_M) ||
                               ((cur_mode == LVL_S) && !tsr));
    end

    // Final strobes towards the state registers and the pipeline.
    always_comb begin
        mret_go = mret_req && mret_legal;
        sret_go = sret_req && sret_legal;
        illegal = (mret_req && !mret_legal) || (sret_req && !sret_legal);
    end

    // R7
    sret_in_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_S && sret_valid && !mret_valid && !trap_valid && cur_mode == LVL_M) |-> !illegal);

endmodule

// File: rtl/priv_state_regs.sv
// Module priv_state_regs
// Holds the hidden current level and the status fields that trap entry,
// returns and software writes act on. Software writes are filtered so
// that only supported encodings are stored. Assumes mret_go / sret_go
// are already legal and that a trap pre-empts both.
module priv_state_regs
    import priv_pkg::*;
#(
    parameter int MODES = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  trap_valid,
    input  logic  trap_to_s,
    input  logic  mret_go,
    input  logic  sret_go,
    input  logic  illegal,
    input  logic  wr_valid,
    input  logic  wr_mprv,
    input  priv_t wr_mpp,
    input  logic  wr_spp,
    input  logic  wr_tsr,
    output priv_t cur_mode,
    output priv_t mpp,
    output logic  spp,
    output logic  mprv,
    output logic  tsr
);
    localparam bit    HAS_U     = (MODES >= 2);
    localparam bit    HAS_S     = (MODES >= 3);
    localparam priv_t RESET_MPP = HAS_U ? LVL_U : LVL_M;

    priv_t mode_d;
    priv_t mpp_d;
    logic  spp_d;
    logic  mprv_d;
    logic  tsr_d;
    logic  trap_into_s;
    logic  any_event;
    logic  mpp_wr_ok;

    // Supported-encoding filter for a written machine previous field.
    always_comb begin
        mpp_wr_ok = (wr_mpp == LVL_M) ||
                    ((wr_mpp == LVL_U) && HAS_U) ||
                    ((wr_mpp == LVL_S) && HAS_S);
    end

    // Decide whether a trap lands in supervisor level.
    always_comb begin
        trap_into_s = HAS_S && trap_valid && trap_to_s && (cur_mode != LVL_M);
        any_event   = trap_valid || mret_go || sret_go;
    end

    // Next-state selection: event first, then software write, else hold.
    always_comb begin
        mode_d = cur_mode;
        mpp_d  = mpp;
        spp_d  = spp;
        mprv_d = mprv;
        tsr_d  = tsr;
        if (trap_valid) begin
            if (trap_into_s) begin
                mode_d = LVL_S;
                spp_d  = (cur_mode == LVL_S);
            end else begin
                mode_d = LVL_M;
                mpp_d  = cur_mode;
            end
        end else if (mret_go) begin
            mode_d = mpp;
            mpp_d  = RESET_MPP;
            if (mpp != LVL_M) begin
                mprv_d = 1'b0;
            end
        end else if (sret_go) begin
            mode_d = spp ? LVL_S : LVL_U;
            spp_d  = 1'b0;
            mprv_d = 1'b0;
        end else if (wr_valid) begin
            if (mpp_wr_ok) begin
                mpp_d = wr_mpp;
            end
            mprv_d = HAS_U ? wr_mprv : 1'b0;
            spp_d  = HAS_S ? wr_spp  : 1'b0;
            tsr_d  = HAS_S ? wr_tsr  : 1'b0;
        end
    end

    // Hidden level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mode <= LVL_M;
        end else begin
            cur_mode <= mode_d;
        end
    end

    // Status field registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mpp  <= RESET_MPP;
            spp  <= 1'b0;
            mprv <= 1'b0;
            tsr  <= 1'b0;
        end else begin
            mpp  <= mpp_d;
            spp  <= spp_d;
            mprv <= mprv_d;
            tsr  <= tsr_d;
        end
    end

    // R2
    trap_to_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && (!trap_to_s || !HAS_S || cur_mode == LVL_M))
        |=> (cur_mode == LVL_M) && (mpp == $past(cur_mode)));

    // R3
    trap_to_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_S && trap_valid && trap_to_s && cur_mode != LVL_M)
        |=> (cur_mode == LVL_S) && (spp == ($past(cur_mode) == LVL_S)));

    // R4
    mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mret_go |=> (cur_mode == $past(mpp)) && (mpp == RESET_MPP));

    // R5
    sret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sret_go |=> !spp && !mprv && (cur_mode == ($past(spp) ? LVL_S : LVL_U)));

    // R6
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(cur_mode) && $stable(mpp) && $stable(mprv) && $stable(spp));

    // R9
    mpp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mpp != 2'b10) && (HAS_S || mpp != LVL_S));

    // R9
    write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && any_event && !trap_valid && mret_go && mpp == LVL_M) |=> mpp == RESET_MPP);

endmodule

// File: rtl/priv_data_sel.sv
// Module priv_data_sel
// Forms the fetch and data privileges. Fetch always uses the current
// level; loads and stores use the machine previous field while the
// modify-privilege bit is set. Assumes mprv is held at 0 in builds
// without user mode, so no extra gating is needed here.
module priv_data_sel
    import priv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  priv_t cur_mode,
    input  priv_t mpp,
    input  logic  mprv,
    output priv_t fetch_priv,
    output priv_t data_priv
);
    // Select the privilege used by each access class.
    always_comb begin
        fetch_priv = cur_mode;
        data_priv  = mprv ? mpp : cur_mode;
    end

    // R8
    data_never_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != LVL_M) |-> !mprv);

endmodule

// File: rtl/priv_mode_tracker.sv
// Module priv_mode_tracker
// Top of the privilege tracking unit: return legality, hidden level and
// status fields, and fetch/data privilege selection. MODES selects the
// levels present: 1 = machine only, 2 = machine+user, 3 = all three.
// Assumes at most one trap per cycle and that the pipeline raises the
// illegal-instruction exception from ret_illegal in the strobe cycle.
module priv_mode_tracker
    import priv_pkg::*;
#(
    parameter int MODES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trap_valid,
    input  logic       trap_to_s,
    input  logic       mret_valid,
    input  logic       sret_valid,
    input  logic       ctl_wr_valid,
    input  logic       ctl_wr_mprv,
    input  logic [1:0] ctl_wr_mpp,
    input  logic       ctl_wr_spp,
    input  logic       ctl_wr_tsr,
    output logic [1:0] cur_priv,
    output logic [1:0] fetch_priv,
    output logic [1:0] data_priv,
    output logic       ctl_mprv,
    output logic [1:0] ctl_mpp,
    output logic       ctl_spp,
    output logic       ctl_tsr,
    output logic       ret_illegal
);
    priv_t mode_q;
    priv_t mpp_q;
    priv_t fetch_l;
    priv_t data_l;
    logic  spp_q;
    logic  mprv_q;
    logic  tsr_q;
    logic  mret_go;
    logic  sret_go;
    logic  illegal;

    priv_return_check #(.MODES(MODES)) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_valid (trap_valid),
        .mret_valid (mret_valid),
        .sret_valid (sret_valid),
        .cur_mode   (mode_q),
        .tsr        (tsr_q),
        .mret_go    (mret_go),
        .sret_go    (sret_go),
        .illegal    (illegal)
    );

    priv_state_regs #(.MODES(MODES)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_valid (trap_valid),
        .trap_to_s  (trap_to_s),
        .mret_go    (mret_go),
        .sret_go    (sret_go),
        .illegal    (illegal),
        .wr_valid   (ctl_wr_valid),
        .wr_mprv    (ctl_wr_mprv),
        .wr_mpp     (priv_t'(ctl_wr_mpp)),
        .wr_spp     (ctl_wr_spp),
        .wr_tsr     (ctl_wr_tsr),
        .cur_mode   (mode_q),
        .mpp        (mpp_q),
        .spp        (spp_q),
        .mprv       (mprv_q),
        .tsr        (tsr_q)
    );

    priv_data_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_mode   (mode_q),
        .mpp        (mpp_q),
        .mprv       (mprv_q),
        .fetch_priv (fetch_l),
        .data_priv  (data_l)
    );

    // Drive the plain-typed outputs.
    always_comb begin
        cur_priv    = mode_q;
        fetch_priv  = fetch_l;
        data_priv   = data_l;
        ctl_mprv    = mprv_q;
        ctl_mpp     = mpp_q;
        ctl_spp     = spp_q;
        ctl_tsr     = tsr_q;
        ret_illegal = illegal;
    end

endmodule

// File: tb/priv_mode_tracker_test.sv
`timescale 1ns/1ps
module priv_mode_tracker_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic       trap, to_s, mret, sret, wr, w_mprv;
        logic [1:0] w_mpp;
        logic       w_spp, w_tsr, e_ill;
        logic [1:0] e_mode, e_mpp;
        logic       e_spp, e_mprv, e_tsr;
        logic [1:0] e_data;
    } vec_t;

    // Fields: trap to_s mret sret wr | mprv mpp spp tsr | ill mode mpp spp mprv tsr data
    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,2'b00}, // R4 M->U
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b11,2'b00,1'b0,1'b0,1'b0,2'b11}, // R2 U->M
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'b01,1'b0,1'b0, 1'b0,2'b11,2'b01,1'b0,1'b1,1'b0,2'b01}, // R8 data S
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'b10,1'b0,1'b0, 1'b0,2'b11,2'b01,1'b0,1'b1,1'b0,2'b01}, // R9 10 dropped
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b01,2'b00,1'b0,1'b0,1'b0,2'b01}, // R4 M->S mprv clr
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b01,2'b00,1'b1,1'b0,1'b0,2'b01}, // R3 S->S
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b01,2'b00,1'b0,1'b0,1'b0,2'b01}, // R5 to S
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,2'b00}, // R5 to U
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b1,2'b00,2'b00,1'b0,1'b0,1'b0,2'b00}, // R6 sret in U
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b1,2'b00,2'b00,1'b0,1'b0,1'b0,2'b00}, // R6 mret in U
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b01,2'b00,1'b0,1'b0,1'b0,2'b01}, // R3 U->S
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b00,1'b0,1'b1, 1'b0,2'b01,2'b00,1'b0,1'b0,1'b1,2'b01}, // R9 tsr set
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b1,2'b01,2'b00,1'b0,1'b0,1'b1,2'b01}, // R6 sret S tsr
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b11,2'b01,1'b0,1'b0,1'b1,2'b11}, // R2 S->M
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b00,2'b01,1'b0,1'b0,1'b1,2'b00}, // R7 sret in M
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b11,2'b00,1'b0,1'b0,1'b1,2'b11}, // R2 U->M
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,1'b1, 1'b0,2'b11,2'b11,1'b0,1'b1,1'b1,2'b11}, // R9 mpp M
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b11,2'b00,1'b0,1'b1,1'b1,2'b00}, // R4 M->M keep
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b11,2'b11,1'b0,1'b1,1'b1,2'b11}, // R3 from M
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'b01,1'b1,1'b0, 1'b0,2'b11,2'b11,1'b0,1'b1,1'b1,2'b11}, // R9 trap wins
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b01,1'b1,1'b0, 1'b0,2'b11,2'b01,1'b1,1'b0,1'b0,2'b11}, // R9 write
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,2'b01,2'b00,1'b1,1'b0,1'b0,2'b01}  // R9 mret wins
    };

    logic       rst_n;
    logic       trap_valid, trap_to_s, mret_valid, sret_valid;
    logic       wr_valid, wr_mprv, wr_spp, wr_tsr;
    logic [1:0] wr_mpp;
    logic [1:0] cur_priv, fetch_priv, data_priv, mpp;
    logic       mprv, spp, tsr, ill;

    logic       m_trap, m_to_s, m_mret, m_sret, m_wr, m_wmprv, m_wspp, m_wtsr;
    logic [1:0] m_wmpp;
    logic [1:0] m_cur, m_fetch, m_data, m_mpp;
    logic       m_mprv, m_spp, m_tsr, m_ill;

    priv_mode_tracker #(.MODES(3)) uut (
        .clk(clk), .rst_n(rst_n),
        .trap_valid(trap_valid), .trap_to_s(trap_to_s),
        .mret_valid(mret_valid), .sret_valid(sret_valid),
        .ctl_wr_valid(wr_valid), .ctl_wr_mprv(wr_mprv), .ctl_wr_mpp(wr_mpp),
        .ctl_wr_spp(wr_spp), .ctl_wr_tsr(wr_tsr),
        .cur_priv(cur_priv), .fetch_priv(fetch_priv), .data_priv(data_priv),
        .ctl_mprv(mprv), .ctl_mpp(mpp), .ctl_spp(spp), .ctl_tsr(tsr),
        .ret_illegal(ill)
    );

    priv_mode_tracker #(.MODES(2)) uut_mu (
        .clk(clk), .rst_n(rst_n),
        .trap_valid(m_trap), .trap_to_s(m_to_s),
        .mret_valid(m_mret), .sret_valid(m_sret),
        .ctl_wr_valid(m_wr), .ctl_wr_mprv(m_wmprv), .ctl_wr_mpp(m_wmpp),
        .ctl_wr_spp(m_wspp), .ctl_wr_tsr(m_wtsr),
        .cur_priv(m_cur), .fetch_priv(m_fetch), .data_priv(m_data),
        .ctl_mprv(m_mprv), .ctl_mpp(m_mpp), .ctl_spp(m_spp), .ctl_tsr(m_tsr),
        .ret_illegal(m_ill)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_all();
        {trap_valid, trap_to_s, mret_valid, sret_valid, wr_valid, wr_mprv, wr_spp, wr_tsr} = '0;
        wr_mpp = 2'b00;
        {m_trap, m_to_s, m_mret, m_sret, m_wr, m_wmprv, m_wspp, m_wtsr} = '0;
        m_wmpp = 2'b00;
    endtask

    // Drive one cycle on the MODES=2 copy and check its flag mid-cycle.
    task automatic mu_step(input logic t, input logic ts, input logic mr, input logic sr,
                           input logic w, input logic wm, input logic [1:0] wp,
                           input logic wt, input int exp_ill);
        m_trap = t; m_to_s = ts; m_mret = mr; m_sret = sr;
        m_wr = w; m_wmprv = wm; m_wmpp = wp; m_wspp = 1'b1; m_wtsr = wt;
        #1 chk("R10", "mu illegal", int'(m_ill), exp_ill);
        @(negedge clk);
        idle_all();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_all();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state of the full build
        chk("R1", "mode", int'(cur_priv), 3);
        chk("R1", "mpp", int'(mpp), 0);
        chk("R1", "spp", int'(spp), 0);
        chk("R1", "mprv", int'(mprv), 0);
        chk("R1", "tsr", int'(tsr), 0);
        chk("R1", "illegal idle", int'(ill), 0);
        chk("R1", "mu mode", int'(m_cur), 3);
        chk("R1", "mu mpp", int'(m_mpp), 0);

        // Vector walk on the full build
        for (int i = 0; i < NV; i++) begin
            trap_valid = VEC[i].trap; trap_to_s = VEC[i].to_s;
            mret_valid = VEC[i].mret; sret_valid = VEC[i].sret;
            wr_valid = VEC[i].wr; wr_mprv = VEC[i].w_mprv; wr_mpp = VEC[i].w_mpp;
            wr_spp = VEC[i].w_spp; wr_tsr = VEC[i].w_tsr;
            #1 chk("R6", $sformatf("v%0d illegal", i), int'(ill), int'(VEC[i].e_ill));
            @(negedge clk);
            chk("R2", $sformatf("v%0d mode", i), int'(cur_priv), int'(VEC[i].e_mode));
            chk("R4", $sformatf("v%0d mpp", i), int'(mpp), int'(VEC[i].e_mpp));
            chk("R5", $sformatf("v%0d spp", i), int'(spp), int'(VEC[i].e_spp));
            chk("R5", $sformatf("v%0d mprv", i), int'(mprv), int'(VEC[i].e_mprv));
            chk("R9", $sformatf("v%0d tsr", i), int'(tsr), int'(VEC[i].e_tsr));
            chk("R8", $sformatf("v%0d data", i), int'(data_priv), int'(VEC[i].e_data));
            chk("R8", $sformatf("v%0d fetch", i), int'(fetch_priv), int'(VEC[i].e_mode));
            idle_all();
        end

        // R10 machine+user build
        mu_step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 1'b1, 0);
        chk("R10", "mu tsr forced 0", int'(m_tsr), 0);
        chk("R10", "mu spp forced 0", int'(m_spp), 0);
        chk("R10", "mu mpp S dropped", int'(m_mpp), 0);
        chk("R10", "mu mprv writable", int'(m_mprv), 1);
        chk("R10", "mu data uses mpp", int'(m_data), 0);
        mu_step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1);
        chk("R10", "mu mode after bad sret", int'(m_cur), 3);
        mu_step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 0);
        chk("R10", "mu mret to U", int'(m_cur), 0);
        chk("R10", "mu mprv cleared", int'(m_mprv), 0);
        mu_step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 0);
        chk("R10", "mu s-trap goes M", int'(m_cur), 3);
        chk("R10", "mu mpp holds U", int'(m_mpp), 0);

        // R1 reset again from a non-reset state (full build is in S, spp=1)
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "re-reset mode", int'(cur_priv), 3);
        chk("R1", "re-reset spp", int'(spp), 0);
        chk("R1", "re-reset mpp", int'(mpp), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule